// File: doc/BRIEF.md
# Battery protection sequencer

This block is the digital sequencing core of a single-cell lithium protection circuit. It receives comparator decisions that have already been digitised: cell above the overvoltage level, cell below the charge-enable level, FET drop above the overcurrent level, cell below the undervoltage level, cell below the depletion level, charger detected, pack terminal recovered, die too hot, and power-switch pin pulled low. It also receives a slow timebase tick and three host register bits: charge enable, discharge enable and the overtemperature flag as the host last left it. From these inputs it drives the charge and discharge FET enables, the test-current and recovery-charge enables, and the active or sleep mode.

Each fault is qualified by a tick counter of its own and held by a set/release latch of its own. An overvoltage removes only the charge path. An overcurrent or short circuit removes both paths and keeps the test current on until the pack recovers. An undervoltage puts the block to sleep. An overtemperature removes both paths at once and is released only after the host has cleared its flag. Single-cycle pulses tell the host register file when to set its OV, UV, DOC, OT and PS flags. A pulse on `en_force` tells it to rewrite both enable bits to 1 after a wake.

Top module: `batt_guard`

## Requirements
- R1: While reset is high and in the cycle after reset, `act_mode`, `chg_on`, `dis_on`, `test_on`, `rcv_on` and every pulse output are 0, so the block starts in sleep.
- R2: In sleep, `psw_low` or `chgr_det` with `cell_sc` low moves the block to active at the next edge. `en_force` is then high for exactly one cycle. While `cell_sc` is high the block stays in sleep.
- R3: A delayed fault (overvoltage, undervoltage, overcurrent, short circuit) acts only at the edge after its condition has been seen high on its limit number of tick cycles in a row while active. A single low cycle of the condition restarts the count from zero.
- R4: A qualified overvoltage drops `chg_on`, pulses `ov_set` and leaves `dis_on` on. The charge path returns one edge after `cell_lo_ce` or `fet_oc` is seen high.
- R5: On the wake edge, an overvoltage that is present takes effect at once with no qualification delay: `chg_on` stays 0 and `ov_set` pulses.
- R6: A qualified undervoltage pulses `uv_set` and puts the block to sleep. In sleep, `chg_on`, `dis_on`, `test_on` and `rcv_on` are all 0.
- R7: A qualified overcurrent or short circuit drops both FET enables, pulses `doc_set` and raises `test_on`. These hold until `pack_up` is seen high.
- R8: `temp_hot` while active drops both FET enables at the next edge and pulses `ot_set`. They come back only once `temp_hot` and `host_ot` are both seen low.
- R9: `host_ce` = 0 holds `chg_on` at 0 and `host_de` = 0 holds `dis_on` at 0, whatever the faults, except in the wake cycle and the `en_force` cycle, where both bits count as 1.
- R10: `rcv_on` follows `cell_lo_ce` one edge later while active, and is 0 in sleep.
- R11: `ps_set` pulses for one cycle at the edge after `psw_low` rises, in either mode, and not again while the pin stays low.
- R12: When faults overlap, a FET enable is 1 only if no latched fault holds that path off and its host enable bit is 1. Releasing one fault in the cycle another one is set leaves the path off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase strobe that advances the qualification counters |
| cell_ov | input | 1 | Cell above the overvoltage level |
| cell_lo_ce | input | 1 | Cell below the charge-enable level |
| fet_oc | input | 1 | FET drop above the overcurrent level |
| cell_uv | input | 1 | Cell below the undervoltage level |
| cell_sc | input | 1 | Cell below the depletion level |
| chgr_det | input | 1 | Charger detected on the pack terminal |
| pack_up | input | 1 | Pack terminal has risen back after a load fault |
| temp_hot | input | 1 | Die above the temperature limit |
| psw_low | input | 1 | Power-switch pin pulled low |
| host_ce | input | 1 | Host charge-enable bit |
| host_de | input | 1 | Host discharge-enable bit |
| host_ot | input | 1 | Host overtemperature flag bit |
| chg_on | output | 1 | Charge FET enable |
| dis_on | output | 1 | Discharge FET enable |
| test_on | output | 1 | Test-current enable |
| rcv_on | output | 1 | Recovery-charge enable |
| act_mode | output | 1 | 1 in active mode, 0 in sleep |
| en_force | output | 1 | One-cycle request to set both host enable bits to 1 |
| ov_set | output | 1 | Set pulse for the overvoltage flag |
| uv_set | output | 1 | Set pulse for the undervoltage flag |
| doc_set | output | 1 | Set pulse for the overcurrent flag |
| ot_set | output | 1 | Set pulse for the overtemperature flag |
| ps_set | output | 1 | Set pulse for the power-switch flag |

## Verification
The hard collision is the release of one latched fault in the same cycle another fault is set on the same path. The directed case holds an overvoltage, then raises the charge-enable-level input and `temp_hot` together. It expects `chg_on` to stay 0 because the new overtemperature still holds the path, and to return only when both are clear. The random phase toggles every condition, the host bits and the tick at once, so wakes landing on an overvoltage cycle, qualifications landing on undervoltage sleeps, and releases meeting new sets recur many times. A bench model built from the requirements judges each output on every cycle.

// File: rtl/bg_pkg.sv
package bg_pkg;
  // index of each delayed fault in the qualifier bank
  typedef enum logic [1:0] {Q_OV = 2'd0, Q_UV = 2'd1, Q_OC = 2'd2, Q_SC = 2'd3} qual_e;
  localparam int unsigned NQ = 4;

  // registered drive bundle
  typedef struct packed {
    logic chg;
    logic dis;
    logic tst;
    logic rcv;
    logic frc;
  } drv_t;
endpackage

// File: rtl/bg_qual.sv
// Tick-based qualification counter: hit once cond held for LIMIT ticks.
module bg_qual #(
  parameter int unsigned LIMIT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cond,
  input  logic tick,
  output logic hit
);
  localparam int unsigned W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en || !cond) cnt <= '0;
    else if (tick && cnt != TOP) cnt <= cnt + W'(1);
  end

  assign hit = en && cond && (cnt == TOP);
endmodule

// File: rtl/bg_latch.sv
// Set-dominant fault latch, updated only when upd is high.
module bg_latch (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic set,
  input  logic rel,
  output logic q,
  output logic q_nxt,
  output logic rose
);
  assign q_nxt = upd ? (set | (q & ~rel)) : q;
  assign rose  = upd & set & ~q;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/batt_guard.sv
module batt_guard
  import bg_pkg::*;
#(
  parameter int unsigned OV_TICKS = 10000,
  parameter int unsigned UV_TICKS = 1250,
  parameter int unsigned OC_TICKS = 160,
  parameter int unsigned SC_TICKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cell_ov,
  input  logic cell_lo_ce,
  input  logic fet_oc,
  input  logic cell_uv,
  input  logic cell_sc,
  input  logic chgr_det,
  input  logic pack_up,
  input  logic temp_hot,
  input  logic psw_low,
  input  logic host_ce,
  input  logic host_de,
  input  logic host_ot,
  output logic chg_on,
  output logic dis_on,
  output logic test_on,
  output logic rcv_on,
  output logic act_mode,
  output logic en_force,
  output logic ov_set,
  output logic uv_set,
  output logic doc_set,
  output logic ot_set,
  output logic ps_set
);
  localparam int unsigned LIM [NQ] = '{OV_TICKS, UV_TICKS, OC_TICKS, SC_TICKS};

  logic [NQ-1:0] cond, hit;
  logic act, act_n, wake, ps_prev;
  logic ov_q, ov_n, ov_r;
  logic doc_q, doc_n, doc_r;
  logic ot_q, ot_n, ot_r;
  logic ce_eff, de_eff;
  drv_t drv_q, drv_d;
  logic [4:0] pls_q, pls_d;

  assign cond = {cell_sc, fet_oc, cell_uv, cell_ov};

  for (genvar g = 0; g < NQ; g++) begin : g_qual
    bg_qual #(.LIMIT(LIM[g])) u_q (
      .clk (clk),
      .rst (rst),
      .en  (act),
      .cond(cond[g]),
      .tick(tick),
      .hit (hit[g])
    );
  end

  // mode sequencing
  assign wake  = !act && (psw_low || chgr_det) && !cell_sc;
  assign act_n = act ? !hit[Q_UV] : wake;

  // overvoltage: also evaluated on the wake edge with no delay
  bg_latch u_ov (
    .clk(clk), .rst(rst),
    .upd (act || wake),
    .set (hit[Q_OV] || (wake && cell_ov)),
    .rel (cell_lo_ce || fet_oc),
    .q(ov_q), .q_nxt(ov_n), .rose(ov_r)
  );

  bg_latch u_doc (
    .clk(clk), .rst(rst),
    .upd (act),
    .set (hit[Q_OC] || hit[Q_SC]),
    .rel (pack_up),
    .q(doc_q), .q_nxt(doc_n), .rose(doc_r)
  );

  bg_latch u_ot (
    .clk(clk), .rst(rst),
    .upd (act),
    .set (temp_hot),
    .rel (!temp_hot && !host_ot),
    .q(ot_q), .q_nxt(ot_n), .rose(ot_r)
  );

  // enables count as 1 while the host bits are being rewritten
  assign ce_eff = host_ce || wake || drv_q.frc;
  assign de_eff = host_de || wake || drv_q.frc;

  always_comb begin
    drv_d.chg = act_n && ce_eff && !ov_n && !doc_n && !ot_n;
    drv_d.dis = act_n && de_eff && !doc_n && !ot_n;
    drv_d.tst = act_n && doc_n;
    drv_d.rcv = act_n && cell_lo_ce;
    drv_d.frc = wake;
    pls_d     = {ov_r, act && hit[Q_UV], doc_r, ot_r, psw_low && !ps_prev};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= 1'b0;
      ps_prev <= 1'b0;
      drv_q   <= '0;
      pls_q   <= '0;
    end else begin
      act     <= act_n;
      ps_prev <= psw_low;
      drv_q   <= drv_d;
      pls_q   <= pls_d;
    end
  end

  assign act_mode = act;
  assign chg_on   = drv_q.chg;
  assign dis_on   = drv_q.dis;
  assign test_on  = drv_q.tst;
  assign rcv_on   = drv_q.rcv;
  assign en_force = drv_q.frc;
  assign ov_set   = pls_q[4];
  assign uv_set   = pls_q[3];
  assign doc_set  = pls_q[2];
  assign ot_set   = pls_q[1];
  assign ps_set   = pls_q[0];
endmodule

// File: rtl/batt_guard_chk.sv
module batt_guard_chk (
  input logic clk,
  input logic rst,
  input logic cell_sc,
  input logic temp_hot,
  input logic host_ce,
  input logic host_de,
  input logic chg_on,
  input logic dis_on,
  input logic test_on,
  input logic rcv_on,
  input logic act_mode,
  input logic en_force,
  input logic ov_set,
  input logic uv_set,
  input logic doc_set
);
  AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (rst)
    !act_mode |-> (!chg_on && !dis_on && !test_on && !rcv_on)); // R6
  AST_UV_SLEEP: assert property (@(posedge clk) disable iff (rst)
    uv_set |-> !act_mode); // R6
  AST_FORCE_ONE: assert property (@(posedge clk) disable iff (rst)
    en_force |=> !en_force); // R2
  AST_SC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!act_mode && cell_sc) |=> !act_mode); // R2
  AST_CE_GATE: assert property (@(posedge clk) disable iff (rst)
    (act_mode && !host_ce && !en_force) |=> !chg_on); // R9
  AST_DE_GATE: assert property (@(posedge clk) disable iff (rst)
    (act_mode && !host_de && !en_force) |=> !dis_on); // R9
  AST_OT_CUT: assert property (@(posedge clk) disable iff (rst)
    (act_mode && temp_hot) |=> (!chg_on && !dis_on)); // R8
  AST_DOC_CUT: assert property (@(posedge clk) disable iff (rst)
    doc_set |-> (!chg_on && !dis_on)); // R7
  AST_OV_KEEP: assert property (@(posedge clk) disable iff (rst)
    ov_set |-> !chg_on); // R4
  AST_RCV_ACT: assert property (@(posedge clk) disable iff (rst)
    rcv_on |-> act_mode); // R10
endmodule

bind batt_guard batt_guard_chk u_chk (.*);

// File: tb/sim_batt_guard.sv
`timescale 1ns/1ps
module sim_batt_guard;
  localparam int OVT = 6, UVT = 4, OCT = 3, SCT = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic tick = 0, cell_ov = 0, cell_lo_ce = 0, fet_oc = 0, cell_uv = 0, cell_sc = 0;
  logic chgr_det = 0, pack_up = 0, temp_hot = 0, psw_low = 0;
  logic host_ce = 1, host_de = 1, host_ot = 0;
  logic chg_on, dis_on, test_on, rcv_on, act_mode, en_force;
  logic ov_set, uv_set, doc_set, ot_set, ps_set;

  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  batt_guard #(.OV_TICKS(OVT), .UV_TICKS(UVT), .OC_TICKS(OCT), .SC_TICKS(SCT)) u0 (.*);

  // reference model written from the requirements
  logic m_act, m_ov, m_doc, m_ot, m_frc, m_ps;
  logic e_chg, e_dis, e_tst, e_rcv, e_ovs, e_uvs, e_docs, e_ots, e_pss;
  int mc [4];
  localparam int LM [4] = '{OVT, UVT, OCT, SCT};

  always @(posedge clk) begin : ref_model
    logic c [4];
    logic h [4];
    logic wk, an, s, ovn, dn, otn, cee, dee;
    if (rst) begin
      m_act <= 0; m_ov <= 0; m_doc <= 0; m_ot <= 0; m_frc <= 0; m_ps <= 0;
      {e_chg, e_dis, e_tst, e_rcv, e_ovs, e_uvs, e_docs, e_ots, e_pss} <= '0;
      for (int i = 0; i < 4; i++) mc[i] <= 0;
    end else begin
      c[0] = cell_ov; c[1] = cell_uv; c[2] = fet_oc; c[3] = cell_sc;
      for (int i = 0; i < 4; i++) h[i] = m_act && c[i] && (mc[i] == LM[i]);
      wk  = !m_act && (psw_low || chgr_det) && !cell_sc;
      an  = m_act ? !h[1] : wk;
      s   = h[0] || (wk && cell_ov);
      ovn = (m_act || wk) ? (s || (m_ov && !(cell_lo_ce || fet_oc))) : m_ov;
      dn  = m_act ? ((h[2] || h[3]) || (m_doc && !pack_up)) : m_doc;
      otn = m_act ? (temp_hot || (m_ot && (temp_hot || host_ot))) : m_ot;
      cee = host_ce || wk || m_frc;
      dee = host_de || wk || m_frc;
      e_ovs  <= (m_act || wk) && s && !m_ov;
      e_uvs  <= m_act && h[1];
      e_docs <= m_act && (h[2] || h[3]) && !m_doc;
      e_ots  <= m_act && temp_hot && !m_ot;
      e_pss  <= psw_low && !m_ps;
      e_chg  <= an && cee && !ovn && !dn && !otn;
      e_dis  <= an && dee && !dn && !otn;
      e_tst  <= an && dn;
      e_rcv  <= an && cell_lo_ce;
      m_act <= an; m_ov <= ovn; m_doc <= dn; m_ot <= otn; m_frc <= wk; m_ps <= psw_low;
      for (int i = 0; i < 4; i++)
        mc[i] <= (!m_act || !c[i]) ? 0 : ((tick && mc[i] < LM[i]) ? mc[i] + 1 : mc[i]);
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R4 chg_on", chg_on, e_chg);
    chk("R7 dis_on", dis_on, e_dis);
    chk("R7 test_on", test_on, e_tst);
    chk("R10 rcv_on", rcv_on, e_rcv);
    chk("R6 act_mode", act_mode, m_act);
    chk("R2 en_force", en_force, m_frc);
    chk("R4 ov_set", ov_set, e_ovs);
    chk("R6 uv_set", uv_set, e_uvs);
    chk("R7 doc_set", doc_set, e_docs);
    chk("R8 ot_set", ot_set, e_ots);
    chk("R11 ps_set", ps_set, e_pss);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (!rst) cmp_all();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) step();
    // R1: reset state
    chk("R1 act_mode", act_mode, 1'b0);
    chk("R1 chg_on", chg_on, 1'b0);
    chk("R1 dis_on", dis_on, 1'b0);
    rst = 0;
    step();
    chk("R1 after reset", act_mode | chg_on | dis_on | ps_set, 1'b0);
    // R2: depletion blocks the wake; R11 pulse on pin fall
    cell_sc = 1; psw_low = 1; step();
    chk("R2 no wake below depletion", act_mode, 1'b0);
    chk("R11 ps_set pulse", ps_set, 1'b1);
    cell_sc = 0; step();
    chk("R2 wake", act_mode, 1'b1);
    chk("R2 en_force high", en_force, 1'b1);
    chk("R11 ps_set single", ps_set, 1'b0);
    chk("R2 chg on after wake", chg_on, 1'b1);
    psw_low = 0; step();
    chk("R2 en_force one cycle", en_force, 1'b0);
    // R3/R4: overvoltage qualification
    cell_ov = 1; tick = 1;
    repeat (OVT) step();
    chk("R3 ov not yet", chg_on, 1'b1);
    step();
    chk("R4 chg off", chg_on, 1'b0);
    chk("R4 dis stays", dis_on, 1'b1);
    chk("R4 ov_set", ov_set, 1'b1);
    cell_ov = 0; cell_lo_ce = 1; step();
    chk("R4 release below ce", chg_on, 1'b1);
    chk("R10 rcv on", rcv_on, 1'b1);
    cell_lo_ce = 0; step();
    chk("R10 rcv off", rcv_on, 1'b0);
    // R3: dropout restarts the count
    cell_ov = 1; repeat (4) step();
    cell_ov = 0; step();
    cell_ov = 1; repeat (OVT) step();
    chk("R3 restart", chg_on, 1'b1);
    step();
    chk("R3 qualified", chg_on, 1'b0);
    cell_ov = 0; tick = 0; fet_oc = 1; step();
    chk("R4 release by discharge", chg_on, 1'b1);
    fet_oc = 0; step();
    // R9: host enables
    host_ce = 0; step();
    chk("R9 ce off", chg_on, 1'b0);
    chk("R9 dis kept", dis_on, 1'b1);
    host_ce = 1; host_de = 0; step();
    chk("R9 de off", dis_on, 1'b0);
    chk("R9 chg kept", chg_on, 1'b1);
    host_de = 1; step();
    // R8: overtemperature
    temp_hot = 1; step();
    chk("R8 both off", chg_on | dis_on, 1'b0);
    chk("R8 ot_set", ot_set, 1'b1);
    temp_hot = 0; host_ot = 1; step();
    chk("R8 waits host", dis_on, 1'b0);
    host_ot = 0; step();
    chk("R8 released", dis_on & chg_on, 1'b1);
    // R7: overcurrent
    fet_oc = 1; tick = 1;
    repeat (OCT) step();
    chk("R7 oc not yet", dis_on, 1'b1);
    step();
    chk("R7 both off", chg_on | dis_on, 1'b0);
    chk("R7 doc_set", doc_set, 1'b1);
    chk("R7 test on", test_on, 1'b1);
    fet_oc = 0; step();
    chk("R7 hold", dis_on, 1'b0);
    chk("R7 test held", test_on, 1'b1);
    pack_up = 1; step();
    chk("R7 recovered", dis_on, 1'b1);
    chk("R7 test off", test_on, 1'b0);
    pack_up = 0;
    // R7: short circuit
    cell_sc = 1; repeat (SCT) step();
    step();
    chk("R7 short off", dis_on, 1'b0);
    cell_sc = 0; pack_up = 1; step();
    pack_up = 0;
    // R12: release of OV meets a new OT set
    cell_ov = 1; repeat (OVT + 1) step();
    chk("R12 ov held", chg_on, 1'b0);
    cell_ov = 0; cell_lo_ce = 1; temp_hot = 1; step();
    chk("R12 still off", chg_on, 1'b0);
    temp_hot = 0; cell_lo_ce = 0; step();
    chk("R12 both clear", chg_on, 1'b1);
    // R6: undervoltage
    cell_uv = 1; repeat (UVT) step();
    chk("R6 not yet", act_mode, 1'b1);
    step();
    chk("R6 sleep", act_mode, 1'b0);
    chk("R6 uv_set", uv_set, 1'b1);
    chk("R6 outputs off", chg_on | dis_on, 1'b0);
    cell_uv = 0; step();
    // R5: wake onto overvoltage acts at once
    cell_ov = 1; chgr_det = 1; step();
    chk("R5 active", act_mode, 1'b1);
    chk("R5 chg off", chg_on, 1'b0);
    chk("R5 ov_set", ov_set, 1'b1);
    chk("R5 dis on", dis_on, 1'b1);
    cell_ov = 0; chgr_det = 0; cell_lo_ce = 1; step();
    cell_lo_ce = 0; step();
    // random phase
    for (int k = 0; k < 4000; k++) begin
      tick = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) cell_ov    = ~cell_ov;
      if ($urandom_range(0, 15) == 0) cell_lo_ce = ~cell_lo_ce;
      if ($urandom_range(0, 15) == 0) fet_oc     = ~fet_oc;
      if ($urandom_range(0, 23) == 0) cell_uv    = ~cell_uv;
      if ($urandom_range(0, 31) == 0) cell_sc    = ~cell_sc;
      if ($urandom_range(0, 15) == 0) chgr_det   = ~chgr_det;
      if ($urandom_range(0, 11) == 0) pack_up    = ~pack_up;
      if ($urandom_range(0, 23) == 0) temp_hot   = ~temp_hot;
      if ($urandom_range(0, 11) == 0) psw_low    = ~psw_low;
      if ($urandom_range(0, 19) == 0) host_ce    = ~host_ce;
      if ($urandom_range(0, 19) == 0) host_de    = ~host_de;
      if ($urandom_range(0, 9) == 0)  host_ot    = ~host_ot;
      step();
    end
    summary();
    $finish;
  end
endmodule